// File: doc/BRIEF.md
# Throttle Duration Search Engine

This engine turns a requested effective clock rate into a pair of tick counts for a stop-clock pulse generator: how many ticks the core clock runs (OFF count, core not suspended) and how many it is held stopped (ON count) in each modulation period. The effective rate of such a pattern is the full-speed rate scaled by OFF over the period length.

No single division yields the best pair, so the engine searches exhaustively. It walks every allowed period length from the longest down to one tick. For each length it derives the OFF count and computes the rate that pair would really achieve. It keeps the candidate nearest the request. One shared restoring divider, one quotient bit per clock, does both divisions for each candidate.

A caller raises `start` for one cycle with the request, the full-speed rate and the longest allowed period. It then waits for the one-cycle `done` pulse and reads the counts, the achieved rate and whether modulation should be on. Range policy, clamping against policy limits and writing the results into registers are left to the surrounding logic.

Top module: `thr_dur_search`

## Requirements
- R1: A requested longest period above 255 ticks is treated as 255, so that search and the one run with the request set to exactly 255 give identical results.
- R2: Period lengths i are tried from the clamped longest down to 1. For each, OFF = floor(target·i / fullspeed) kept to its low 8 bits, and ON = (i − OFF) mod 256.
- R3: The rate of a candidate is floor(fullspeed·OFF / i). `achFreq` reports the rate of the chosen candidate.
- R4: A candidate displaces the best so far when |rate − target| is less than or equal to the best error. Among equal errors the shortest period wins. Example: fullspeed 100, target 50, longest 4 gives ON 1, OFF 1, rate 50. The starting best is rate = fullspeed.
- R5: When the chosen rate equals fullspeed, `modEn` is 0 and both counts are 0. Otherwise `modEn` is 1 and the counts are those of the chosen candidate.
- R6: A `start` seen while idle captures the inputs. `busy` then stays high until a single-cycle `done`, during which `busy` is low and the results are already valid.
- R7: A `start` raised while `busy` is high has no effect: the running search ends with the results of its own captured inputs.
- R8: If fullspeed is 0 or the longest period is 0, the next cycle gives `done` with `errFlag` = 1, no busy phase, and all result outputs unchanged. `errFlag` is 0 after any successful search.
- R9: After reset, `busy`, `done`, `errFlag` and `modEn` are 0, and `onCnt`, `offCnt` and `achFreq` are 0.
- R10: From the accepted `start` to `done`, a search takes no more than P·(2·PW+8)+6 cycles. Here P is the clamped period and PW the product width (40 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| tgtFreq | input | 32 | Requested rate, kHz |
| fullFreq | input | 32 | Unthrottled rate, kHz |
| maxPeriod | input | 16 | Longest allowed period in ticks (clamped to 255) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last completion rejected the inputs |
| modEn | output | 1 | Modulation should be enabled |
| onCnt | output | 8 | Ticks with the clock stopped |
| offCnt | output | 8 | Ticks with the clock running |
| achFreq | output | 40 | Rate the chosen pair achieves, kHz |

## Verification
The bench builds the engine with its default widths: 32-bit rates, 8-bit counts and 40-bit products. It keeps most random requests to longest periods of 40 ticks or less, so many searches fit in the cycle budget. A single request of 300 ticks reaches the clamp and the worst-case latency. Directed jobs reach the tie rule, the exact full-speed case, a zero target and both rejected configurations.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef struct packed {
    logic latch;
    logic div1Go;
    logic div2Go;
    logic capOff;
    logic capCand;
    logic evalCand;
    logic stepDown;
    logic publish;
  } thr_strobe_t;

  typedef struct packed {
    logic divDone;
    logic lastPeriod;
    logic badCfg;
  } thr_status_t;
endpackage

// File: rtl/thr_div.sv
module thr_div #(
  parameter int DVD_W = 40,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic [DVD_W-1:0] quo,
  output logic             fin
);
  localparam int CW = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem, dvsR;
  logic [DVD_W-1:0] acc;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DVS_W:0]   trial, diff;
  logic             geq;

  always_comb begin
    trial = {rem, acc[DVD_W-1]};
    geq   = trial >= {1'b0, dvsR};
    diff  = trial - {1'b0, dvsR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem <= '0; dvsR <= '0; acc <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
    end else if (go) begin
      rem <= '0; dvsR <= dvs; acc <= dvd; cnt <= CW'(DVD_W); run <= 1'b1; fin <= 1'b0;
    end else if (run) begin
      rem <= geq ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      acc <= {acc[DVD_W-2:0], geq};
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quo = acc;
endmodule

// File: rtl/thr_ctl.sv
module thr_ctl
  import thr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  thr_status_t stat,
  output thr_strobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        errFlag
);
  typedef enum logic [2:0] {S_IDLE, S_D1GO, S_D1RUN, S_D2GO, S_D2RUN, S_EVAL, S_FIN} state_t;
  state_t state, nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      S_IDLE:  if (start && !stat.badCfg) begin stb.latch = 1'b1; nxt = S_D1GO; end
      S_D1GO:  begin stb.div1Go = 1'b1; nxt = S_D1RUN; end
      S_D1RUN: if (stat.divDone) begin stb.capOff = 1'b1; nxt = S_D2GO; end
      S_D2GO:  begin stb.div2Go = 1'b1; nxt = S_D2RUN; end
      S_D2RUN: if (stat.divDone) begin stb.capCand = 1'b1; nxt = S_EVAL; end
      S_EVAL:  begin
        stb.evalCand = 1'b1;
        if (stat.lastPeriod) nxt = S_FIN;
        else begin stb.stepDown = 1'b1; nxt = S_D1GO; end
      end
      S_FIN:   begin stb.publish = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; done <= 1'b0; errFlag <= 1'b0;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      if (state == S_IDLE && start && stat.badCfg) begin
        done <= 1'b1; errFlag <= 1'b1;
      end else if (state == S_FIN) begin
        done <= 1'b1; errFlag <= 1'b0;
      end
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/thr_dp.sv
module thr_dp
  import thr_pkg::*;
#(
  parameter int FW = 32,
  parameter int CW = 8,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  thr_strobe_t   stb,
  input  logic [FW-1:0] tgtIn,
  input  logic [FW-1:0] fsIn,
  input  logic [MW-1:0] maxIn,
  output thr_status_t   stat,
  output logic          modEn,
  output logic [CW-1:0] onCnt,
  output logic [CW-1:0] offCnt,
  output logic [FW+CW-1:0] achFreq
);
  localparam int PW   = FW + CW;
  localparam int MAXP = (1 << CW) - 1;

  logic [FW-1:0] tgtR, fsR;
  logic [CW-1:0] perR, offCand, bestOn, bestOff, perClamp;
  logic [PW-1:0] candF, bestF, dvdMux, quo;
  logic [FW-1:0] dvsMux;
  logic [PW:0]   candErr, bestErr;
  logic          divFin;

  function automatic logic [PW:0] absDiff(input logic [PW-1:0] a, input logic [FW-1:0] b);
    logic [PW:0] d;
    d = {1'b0, a} - (PW+1)'(b);
    return d[PW] ? (~d + 1'b1) : d;
  endfunction

  always_comb begin
    perClamp = (maxIn > MW'(MAXP)) ? CW'(MAXP) : maxIn[CW-1:0];
    dvdMux   = stb.div1Go ? PW'(tgtR) * PW'(perR) : PW'(fsR) * PW'(offCand);
    dvsMux   = stb.div1Go ? fsR : FW'(perR);
    candErr  = absDiff(candF, tgtR);
    bestErr  = absDiff(bestF, tgtR);
    stat.divDone    = divFin;
    stat.lastPeriod = (perR == CW'(1));
    stat.badCfg     = (fsIn == '0) || (maxIn == '0);
  end

  thr_div #(.DVD_W(PW), .DVS_W(FW)) u_div (
    .clk(clk), .rstN(rstN), .go(stb.div1Go | stb.div2Go),
    .dvd(dvdMux), .dvs(dvsMux), .quo(quo), .fin(divFin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtR <= '0; fsR <= '0; perR <= '0; offCand <= '0; candF <= '0;
      bestF <= '0; bestOn <= '0; bestOff <= '0;
      modEn <= 1'b0; onCnt <= '0; offCnt <= '0; achFreq <= '0;
    end else begin
      if (stb.latch) begin
        tgtR <= tgtIn; fsR <= fsIn; perR <= perClamp;
        bestF <= PW'(fsIn); bestOff <= CW'(1); bestOn <= '0;
      end
      if (stb.capOff)   offCand <= quo[CW-1:0];
      if (stb.capCand)  candF <= quo;
      if (stb.evalCand && candErr <= bestErr) begin
        bestF <= candF; bestOff <= offCand; bestOn <= perR - offCand;
      end
      if (stb.stepDown) perR <= perR - 1'b1;
      if (stb.publish) begin
        achFreq <= bestF;
        if (bestF == PW'(fsR)) begin
          modEn <= 1'b0; onCnt <= '0; offCnt <= '0;
        end else begin
          modEn <= 1'b1; onCnt <= bestOn; offCnt <= bestOff;
        end
      end
    end
  end
endmodule

// File: rtl/thr_dur_search.sv
module thr_dur_search
  import thr_pkg::*;
#(
  parameter int FW = 32,
  parameter int CW = 8,
  parameter int MW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [FW-1:0]    tgtFreq,
  input  logic [FW-1:0]    fullFreq,
  input  logic [MW-1:0]    maxPeriod,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic             modEn,
  output logic [CW-1:0]    onCnt,
  output logic [CW-1:0]    offCnt,
  output logic [FW+CW-1:0] achFreq
);
  thr_strobe_t stb;
  thr_status_t stat;

  thr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .stb(stb),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  thr_dp #(.FW(FW), .CW(CW), .MW(MW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtIn(tgtFreq), .fsIn(fullFreq),
    .maxIn(maxPeriod), .stat(stat), .modEn(modEn), .onCnt(onCnt),
    .offCnt(offCnt), .achFreq(achFreq)
  );
endmodule

// File: rtl/thr_dur_search_chk.sv
module thr_dur_search_chk #(
  parameter int FW = 32,
  parameter int CW = 8,
  parameter int MW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [MW-1:0]    maxPeriod,
  input logic             busy,
  input logic             done,
  input logic             errFlag,
  input logic             modEn,
  input logic [CW-1:0]    onCnt,
  input logic [CW-1:0]    offCnt,
  input logic [FW+CW-1:0] achFreq
);
  localparam int PW   = FW + CW;
  localparam int MAXP = (1 << CW) - 1;
  localparam int LAT_MAX = MAXP * (2 * PW + 8) + 6;

  logic [31:0] busyCyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCyc <= '0;
    else if (busy) busyCyc <= busyCyc + 1'b1;
    else busyCyc <= '0;
  end

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rstN) busy |=> (busy || done));
  a_r5_zero_counts: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag && !modEn) |-> (onCnt == '0 && offCnt == '0));
  a_r8_err_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> ($stable(onCnt) && $stable(offCnt) && $stable(achFreq) && $stable(modEn)));
  a_r8_no_busy_err: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> !$past(busy));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN) busyCyc <= 32'(LAT_MAX));
endmodule

bind thr_dur_search thr_dur_search_chk #(.FW(FW), .CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .maxPeriod(maxPeriod), .busy(busy),
  .done(done), .errFlag(errFlag), .modEn(modEn), .onCnt(onCnt),
  .offCnt(offCnt), .achFreq(achFreq)
);

// File: tb/thr_dur_search_bench.sv
module thr_dur_search_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tgtFreq = '0, fullFreq = '0;
  logic [15:0] maxPeriod = '0;
  logic        busy, done, errFlag, modEn;
  logic [7:0]  onCnt, offCnt;
  logic [39:0] achFreq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  thr_dur_search u_thr_dur_search (
    .clk(clk), .rstN(rstN), .start(start), .tgtFreq(tgtFreq),
    .fullFreq(fullFreq), .maxPeriod(maxPeriod), .busy(busy), .done(done),
    .errFlag(errFlag), .modEn(modEn), .onCnt(onCnt), .offCnt(offCnt),
    .achFreq(achFreq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint t, input longint f, input longint m,
                                output longint on, output longint off,
                                output longint fr, output longint en);
    longint p, bo, bf, bon, o, n, c, ec, eb;
    p = (m > 255) ? 255 : m;
    bf = f; bo = 1; bon = 0;
    for (longint i = p; i > 0; i--) begin
      o = ((t * i) / f) & 255;
      n = (i - o) & 255;
      c = (f * o) / i;
      ec = (c > t) ? c - t : t - c;
      eb = (bf > t) ? bf - t : t - bf;
      if (ec <= eb) begin bf = c; bo = o; bon = n; end
    end
    fr = bf;
    if (bf == f) begin on = 0; off = 0; en = 0; end
    else begin on = bon; off = bo; en = 1; end
  endfunction

  task automatic runJob(input logic [31:0] t, input logic [31:0] f,
                        input logic [15:0] m, output int cyc);
    @(negedge clk);
    tgtFreq = t; fullFreq = f; maxPeriod = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic checkJob(input string req, input logic [31:0] t,
                          input logic [31:0] f, input logic [15:0] m);
    longint eOn, eOff, eFr, eEn, p;
    int cyc;
    runJob(t, f, m, cyc);
    model(t, f, m, eOn, eOff, eFr, eEn);
    p = (m > 255) ? 255 : m;
    chk({req, " done"}, done, 1);
    chk({req, " errFlag"}, errFlag, 0);
    chk({req, " onCnt"}, onCnt, eOn);
    chk({req, " offCnt"}, offCnt, eOff);
    chk({req, " achFreq"}, achFreq, eFr);
    chk({req, " modEn"}, modEn, eEn);
    chk({req, " R10 latency in bound"}, longint'(cyc <= p * 88 + 6), 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] sOn, sOff;
    logic [39:0] sFr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset values
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 errFlag", errFlag, 0);
    chk("R9 modEn", modEn, 0);
    chk("R9 onCnt", onCnt, 0);
    chk("R9 offCnt", offCnt, 0);
    chk("R9 achFreq", achFreq, 0);

    // R4 tie rule: 100/50/4 -> on 1 off 1 rate 50
    checkJob("R4 tie", 32'd50, 32'd100, 16'd4);
    chk("R4 tie on", onCnt, 1);
    chk("R4 tie off", offCnt, 1);
    chk("R3 tie rate", achFreq, 50);

    // R5 exact full speed
    checkJob("R5 fullspeed", 32'd200000, 32'd200000, 16'd20);
    chk("R5 modEn low", modEn, 0);
    chk("R5 counts zero", {onCnt, offCnt}, 0);

    // R2 zero target
    checkJob("R2 zero target", 32'd0, 32'd133000, 16'd12);
    chk("R2 zero target off", offCnt, 0);
    chk("R2 zero target on", onCnt, 1);

    // R6 handshake: busy high after start
    @(negedge clk);
    tgtFreq = 32'd70000; fullFreq = 32'd233000; maxPeriod = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 busy after start", busy, 1);
    // R7 start during busy with other inputs
    repeat (10) @(negedge clk);
    tgtFreq = 32'd5; fullFreq = 32'd0; maxPeriod = 16'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 still busy", busy, 1);
    chk("R7 no error pulse", errFlag, 0);
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk("R6 done seen", done, 1);
    chk("R6 busy low at done", busy, 0);
    begin
      longint eOn, eOff, eFr, eEn;
      model(70000, 233000, 9, eOn, eOff, eFr, eEn);
      chk("R7 own inputs on", onCnt, eOn);
      chk("R7 own inputs off", offCnt, eOff);
      chk("R7 own inputs rate", achFreq, eFr);
    end
    @(negedge clk);
    chk("R6 done single cycle", done, 0);

    // R8 rejected inputs keep results
    sOn = onCnt; sOff = offCnt; sFr = achFreq;
    runJob(32'd1000, 32'd0, 16'd10, cyc);
    chk("R8 fs zero done", done, 1);
    chk("R8 fs zero err", errFlag, 1);
    chk("R8 fs zero quick", cyc, 1);
    chk("R8 fs zero keeps on", onCnt, sOn);
    chk("R8 fs zero keeps rate", achFreq, sFr);
    runJob(32'd1000, 32'd50000, 16'd0, cyc);
    chk("R8 period zero err", errFlag, 1);
    chk("R8 period zero keeps off", offCnt, sOff);

    // R1 clamp: 300 requested
    checkJob("R1 clamp 300", 32'd48000, 32'd200000, 16'd300);

    // R2 R3 R4 random jobs
    for (int k = 0; k < 14; k++) begin
      logic [31:0] f, t;
      logic [15:0] m;
      f = 32'd1000 + ($urandom % 32'd300000);
      t = $urandom % (f + f / 4);
      m = 16'd1 + 16'($urandom % 32'd40);
      checkJob("R2 R3 R4 random", t, f, m);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule